// File: doc/BRIEF.md
# Host/Peer Doorbell Mailbox with Circular Buffers

This block is a register-mapped mailbox between a host and an embedded peer. The host writes words through a push window into an outbound circular buffer that the peer drains through a word pop port. The peer fills an inbound circular buffer through a word push port, and the host drains it through a pop window. Each direction has a status word that carries the buffer depth, a read pointer and a write pointer. The pointers run freely modulo 256, so software derives the occupancy by subtraction and can detect overflow.

A host control register holds an interrupt enable bit and a pending-interrupt flag. The pending flag is write-one-to-clear and is set by a peer event. The register also holds a doorbell trigger bit and the host ready and host reset bits. Start-up follows a handshake. The host holds reset, then releases it, which empties both buffers and clears pending events. Once the peer reports ready, the host sets its own ready bit. After the last word of a message has been pushed, the host sets the doorbell trigger to notify the peer.

Host window map (`hst_addr`): 0 = push window (write-only; reads return 0), 1 = host control/status, 2 = pop window, 3 = peer status. Host control bits: 0 interrupt enable, 1 pending interrupt (write-one-to-clear), 2 doorbell trigger (reads 0), 3 host ready, 4 host reset, 5 outbound overflow (read-only, sticky). Peer status bits: 0 peer ready, 5 inbound overflow (sticky). In both status words, bits 15:8 hold the read pointer, bits 23:16 the write pointer and bits 31:24 the depth.

Top module: `mbox_ctrl`

## Requirements
- R1: Host control/status (window 1) and peer status (window 3) carry the constant buffer depth in bits 31:24, the read pointer in bits 15:8 and the write pointer in bits 23:16. Host reads return data one cycle after the read strobe. After reset, both words read as depth<<24 with all other bits zero, except that peer status bit 0 follows `peer_ready`.
- R2: Each host write to window 0 pushes one word into the outbound buffer and advances its write pointer by one. The peer sees the oldest word on `pr_pop_data` while `pr_has_data` is high, and each `pr_pop` advances the read pointer by one.
- R3: A push into a full buffer (write pointer minus read pointer equal to the depth) is dropped. The dropped push sets the sticky overflow bit 5 of that buffer's status word, and the occupancy never exceeds the depth.
- R4: Each host read of window 2 pops and returns the oldest inbound word. A read from an empty inbound buffer returns 0 and leaves both pointers unchanged.
- R5: Pointers are 8-bit and wrap modulo 256 independently of the depth.
- R6: Control bit 1 is set by a `peer_event` pulse and cleared by writing 1 to it. Writing 0 to it leaves it unchanged.
- R7: `host_irq` is high exactly when control bits 0 and 1 are both set.
- R8: Writing 1 to control bit 2 gives a one-cycle `doorbell` pulse in the cycle after the write. Bit 2 always reads 0.
- R9: Writing 1 to control bit 4 while it is clear sets it and clears host ready. While bit 4 is set, writing 1 to it again has no effect. Writing 0 to it releases reset, which zeroes both pointer pairs and clears both overflow flags, the pending interrupt and any doorbell.
- R10: Writing 1 to control bit 3 sets host ready only while `peer_ready` is high and bit 4 is clear. Writing 0 to bit 3 clears host ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 2 | Host window select |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid the cycle after `hst_rd` |
| host_irq | output | 1 | Interrupt to the host |
| host_ready | output | 1 | Host ready bit |
| host_in_reset | output | 1 | Host reset bit |
| doorbell | output | 1 | One-cycle notification to the peer |
| peer_ready | input | 1 | Peer ready level |
| peer_event | input | 1 | Peer interrupt request pulse |
| pr_pop | input | 1 | Peer pops one outbound word |
| pr_pop_data | output | 32 | Oldest outbound word |
| pr_has_data | output | 1 | Outbound buffer not empty |
| pr_push | input | 1 | Peer pushes one inbound word |
| pr_push_data | input | 32 | Inbound word |
| pr_can_push | output | 1 | Inbound buffer not full |

## Verification
A pointer that is off by one shows up in the pointer field of the next status read, and in the word seen at `pr_pop_data` or returned by the pop window. Both appear within one host read after the bad push or pop. A lost overflow flag or a pointer that fails to wrap shows up as a wrong bit 5 or a wrong pointer field on the following status read. A control bit that is wrongly kept or cleared, such as a pending flag erased by a zero write or a reset that can be re-entered, shows up at the next control read or on `host_irq`, `doorbell` and `host_ready` one cycle after the offending write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef enum logic [1:0] {
      WIN_PUSH  = 2'd0,
      WIN_HCTL  = 2'd1,
      WIN_POP   = 2'd2,
      WIN_PSTAT = 2'd3
   } mbox_win_e;

   localparam int unsigned B_IE   = 0;
   localparam int unsigned B_PEND = 1;
   localparam int unsigned B_BELL = 2;
   localparam int unsigned B_RDY  = 3;
   localparam int unsigned B_RST  = 4;
   localparam int unsigned B_OVF  = 5;
   localparam int unsigned B_PRDY = 0;

   localparam int unsigned CTL_W  = 5;
   localparam int unsigned PTR_W  = 8;

   function automatic logic [31:0] status_word(input logic [7:0] depth,
                                               input logic [7:0] wr_p,
                                               input logic [7:0] rd_p,
                                               input logic [7:0] flags);
      return {depth, wr_p, rd_p, flags};
   endfunction

   function automatic bit depth_ok(input int unsigned d);
      return (d >= 2) && (d <= 128) && ((d & (d - 1)) == 0);
   endfunction

endpackage

// File: rtl/mbox_ring.sv
module mbox_ring
   import mbox_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [DW-1:0]    push_data,
   input  logic             pop,
   output logic [DW-1:0]    head_data,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W-1:0] wr_ptr,
   output logic             empty,
   output logic             ovf
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

   logic [PTR_W-1:0] occ;
   logic             full;
   logic [DW-1:0]    slots [DEPTH];

   assign occ   = wr_ptr - rd_ptr;
   assign full  = (occ == DEPTH_P);
   assign empty = (occ == '0);

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [DW-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (push && !full && (wr_ptr[AW-1:0] == AW'(i)))
               slot_q <= push_data;
         end
         assign slots[i] = slot_q;
      end
   endgenerate

   assign head_data = empty ? '0 : slots[rd_ptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         ovf    <= 1'b0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         ovf    <= 1'b0;
      end else begin
         if (push && !full) wr_ptr <= wr_ptr + 1'b1;
         if (push && full)  ovf    <= 1'b1;
         if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   // R3: occupancy is bounded by the depth
   assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr - rd_ptr) <= DEPTH_P);

   // R3: a push into a full buffer leaves the write pointer in place
   assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !clr) |=> (wr_ptr == $past(wr_ptr)));

   // R4: a pop from an empty buffer leaves the read pointer in place
   assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !clr) |=> (rd_ptr == $past(rd_ptr)));

endmodule

// File: rtl/mbox_ctl.sv
module mbox_ctl
   import mbox_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             peer_ready,
   input  logic             peer_event,
   output logic             ie_q,
   output logic             pend_q,
   output logic             rdy_q,
   output logic             rst_q,
   output logic             bell_q,
   output logic             release_now
);

   logic start_rst;

   assign release_now = ctl_we && rst_q && !ctl_wdata[B_RST];
   assign start_rst   = ctl_we && !rst_q && ctl_wdata[B_RST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         pend_q <= 1'b0;
         rdy_q  <= 1'b0;
         rst_q  <= 1'b0;
         bell_q <= 1'b0;
      end else begin
         if (ctl_we) begin
            ie_q  <= ctl_wdata[B_IE];
            rst_q <= ctl_wdata[B_RST];
         end

         if (release_now)
            pend_q <= 1'b0;
         else if (peer_event)
            pend_q <= 1'b1;
         else if (ctl_we && ctl_wdata[B_PEND])
            pend_q <= 1'b0;

         if (start_rst)
            rdy_q <= 1'b0;
         else if (ctl_we) begin
            if (!ctl_wdata[B_RDY])
               rdy_q <= 1'b0;
            else if (peer_ready && !rst_q)
               rdy_q <= 1'b1;
         end

         bell_q <= ctl_we && ctl_wdata[B_BELL] && !release_now;
      end
   end

   // R6: a zero written to the pending bit keeps it
   assert_pend_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && ctl_we && !ctl_wdata[B_PEND] && !release_now) |=> pend_q);

   // R8: every doorbell pulse comes from a trigger write
   assert_bell_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bell_q |-> $past(ctl_we && ctl_wdata[B_BELL]));

   // R9: reset cannot be re-entered while it is held
   assert_rst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_q && ctl_we && ctl_wdata[B_RST]) |=> rst_q);

   // R9: entering reset drops host ready
   assert_rst_drops_rdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_q) |-> !rdy_q);

   // R10: host ready only rises after the peer reported ready
   assert_rdy_after_peer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_q) |-> $past(peer_ready));

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
   import mbox_pkg::*;
#(
   parameter int unsigned OUT_DEPTH = 16,
   parameter int unsigned IN_DEPTH  = 16,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hst_wr,
   input  logic        hst_rd,
   input  logic [1:0]  hst_addr,
   input  logic [31:0] hst_wdata,
   output logic [31:0] hst_rdata,
   output logic        host_irq,
   output logic        host_ready,
   output logic        host_in_reset,
   output logic        doorbell,
   input  logic        peer_ready,
   input  logic        peer_event,
   input  logic        pr_pop,
   output logic [31:0] pr_pop_data,
   output logic        pr_has_data,
   input  logic        pr_push,
   input  logic [31:0] pr_push_data,
   output logic        pr_can_push
);

   localparam int unsigned WORD_W = 32;
   localparam logic [7:0] OUT_D8 = 8'(OUT_DEPTH);
   localparam logic [7:0] IN_D8  = 8'(IN_DEPTH);

   generate
      if (!depth_ok(OUT_DEPTH)) begin : g_bad_out
         $error("OUT_DEPTH must be a power of two in 2..128");
      end
      if (!depth_ok(IN_DEPTH)) begin : g_bad_in
         $error("IN_DEPTH must be a power of two in 2..128");
      end
   endgenerate

   mbox_win_e win;
   logic      out_push, in_pop, ctl_we;
   logic      ie, pend, rdy, rstb, clr;
   logic [PTR_W-1:0] o_rd, o_wr, i_rd, i_wr;
   logic      o_empty, i_empty, o_ovf, i_ovf;
   logic [WORD_W-1:0] i_head;
   logic [7:0] ctl_flags, pst_flags;

   assign win      = mbox_win_e'(hst_addr);
   assign out_push = hst_wr && (win == WIN_PUSH);
   assign ctl_we   = hst_wr && (win == WIN_HCTL);
   assign in_pop   = hst_rd && (win == WIN_POP);

   mbox_ctl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_we      (ctl_we),
      .ctl_wdata   (hst_wdata[CTL_W-1:0]),
      .peer_ready  (peer_ready),
      .peer_event  (peer_event),
      .ie_q        (ie),
      .pend_q      (pend),
      .rdy_q       (rdy),
      .rst_q       (rstb),
      .bell_q      (doorbell),
      .release_now (clr)
   );

   mbox_ring #(.DW(WORD_W), .DEPTH(OUT_DEPTH)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push      (out_push),
      .push_data (hst_wdata),
      .pop       (pr_pop),
      .head_data (pr_pop_data),
      .rd_ptr    (o_rd),
      .wr_ptr    (o_wr),
      .empty     (o_empty),
      .ovf       (o_ovf)
   );

   mbox_ring #(.DW(WORD_W), .DEPTH(IN_DEPTH)) u_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push      (pr_push),
      .push_data (pr_push_data),
      .pop       (in_pop),
      .head_data (i_head),
      .rd_ptr    (i_rd),
      .wr_ptr    (i_wr),
      .empty     (i_empty),
      .ovf       (i_ovf)
   );

   assign pr_has_data   = !o_empty;
   assign pr_can_push   = ((i_wr - i_rd) != IN_D8);
   assign host_ready    = rdy;
   assign host_in_reset = rstb;

   assign ctl_flags = {2'b00, o_ovf, rstb, rdy, 1'b0, pend, ie};
   assign pst_flags = {2'b00, i_ovf, 4'b0000, peer_ready};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hst_rdata <= '0;
      else if (hst_rd) begin
         unique case (win)
            WIN_PUSH:  hst_rdata <= '0;
            WIN_HCTL:  hst_rdata <= status_word(OUT_D8, o_wr, o_rd, ctl_flags);
            WIN_POP:   hst_rdata <= i_head;
            WIN_PSTAT: hst_rdata <= status_word(IN_D8, i_wr, i_rd, pst_flags);
            default:   hst_rdata <= '0;
         endcase
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= ie && pend;
         end
         assign host_irq = irq_q;
      end else begin : g_irq_comb
         assign host_irq = ie && pend;
      end
   endgenerate

   // R7: interrupt only while enabled (checked at the output pin)
   assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie && !$past(ie)) |-> !host_irq);

   // R9: releasing reset empties the outbound buffer
   assert_release_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !pr_has_data);

endmodule

// File: tb/mbox_ctrl_test.sv
`timescale 1ns/1ps
module mbox_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_wr = 1'b0, hst_rd = 1'b0;
   logic [1:0]  hst_addr = 2'd0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] hst_rdata;
   logic        host_irq, host_ready, host_in_reset, doorbell;
   logic        peer_ready = 1'b0, peer_event = 1'b0;
   logic        pr_pop = 1'b0, pr_push = 1'b0;
   logic [31:0] pr_pop_data, pr_push_data = '0;
   logic        pr_has_data, pr_can_push;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] hw = 0, hr = 0, pw = 0, pr = 0;
   bit         hovf = 0, povf = 0;

   always #2.5 clk = ~clk;

   mbox_ctrl uut (
      .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .host_irq(host_irq), .host_ready(host_ready),
      .host_in_reset(host_in_reset), .doorbell(doorbell),
      .peer_ready(peer_ready), .peer_event(peer_event),
      .pr_pop(pr_pop), .pr_pop_data(pr_pop_data), .pr_has_data(pr_has_data),
      .pr_push(pr_push), .pr_push_data(pr_push_data), .pr_can_push(pr_can_push)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
      hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
      tick();
      hst_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
      hst_rd = 1'b1; hst_addr = a;
      tick();
      hst_rd = 1'b0;
      d = hst_rdata;
   endtask

   task automatic host_push(input logic [31:0] d);
      bus_wr(2'd0, d);
      if ((hw - hr) == 8'd16) hovf = 1; else hw++;
   endtask

   task automatic peer_pop_chk(input logic [31:0] exp, input string req);
      chk(pr_pop_data == exp, req, pr_pop_data, exp);
      pr_pop = 1'b1;
      tick();
      pr_pop = 1'b0;
      hr++;
   endtask

   task automatic peer_push(input logic [31:0] d);
      pr_push = 1'b1; pr_push_data = d;
      tick();
      pr_push = 1'b0;
      if ((pw - pr) == 8'd16) povf = 1; else pw++;
   endtask

   task automatic pulse_event;
      peer_event = 1'b1;
      tick();
      peer_event = 1'b0;
   endtask

   function automatic logic [31:0] exp_ctl(input logic [7:0] low);
      return {8'h10, hw, hr, low | (hovf ? 8'h20 : 8'h00)};
   endfunction

   function automatic logic [31:0] exp_pst;
      return {8'h10, pw, pr, (povf ? 8'h20 : 8'h00) | {7'd0, peer_ready}};
   endfunction

   task automatic t_reset_state;
      logic [31:0] d;
      bus_rd(2'd1, d); chk(d == 32'h1000_0000, "R1 ctl after reset", d, 32'h1000_0000);
      bus_rd(2'd3, d); chk(d == 32'h1000_0000, "R1 peer status after reset", d, 32'h1000_0000);
      chk(!host_irq && !doorbell && !pr_has_data, "R1 outputs idle",
          {host_irq, doorbell, pr_has_data}, 0);
   endtask

   task automatic t_push_basic;
      logic [31:0] d;
      for (int i = 0; i < 3; i++) host_push(32'hC0DE_0000 + i);
      bus_rd(2'd1, d); chk(d == exp_ctl(0), "R2 write pointer after 3 pushes", d, exp_ctl(0));
      chk(d == 32'h1003_0000, "R1 field positions", d, 32'h1003_0000);
      for (int i = 0; i < 3; i++) peer_pop_chk(32'hC0DE_0000 + i, "R2 peer word order");
      chk(!pr_has_data, "R2 drained", pr_has_data, 0);
      bus_rd(2'd1, d); chk(d == 32'h1003_0300, "R2 read pointer advanced", d, 32'h1003_0300);
   endtask

   task automatic t_out_full;
      logic [31:0] d;
      for (int i = 0; i < 17; i++) host_push(32'hF00D_0000 + i);
      bus_rd(2'd1, d); chk(d == 32'h1013_0320, "R3 drop and overflow flag", d, 32'h1013_0320);
      for (int i = 0; i < 16; i++) peer_pop_chk(32'hF00D_0000 + i, "R3 kept words");
      chk(!pr_has_data, "R3 dropped word absent", pr_has_data, 0);
   endtask

   task automatic t_in_path;
      logic [31:0] d;
      peer_ready = 1'b1;
      for (int i = 0; i < 17; i++) peer_push(32'hBEEF_0000 + i);
      chk(!pr_can_push, "R3 inbound full", pr_can_push, 0);
      bus_rd(2'd3, d); chk(d == 32'h1010_0021, "R3 inbound overflow status", d, 32'h1010_0021);
      for (int i = 0; i < 16; i++) begin
         bus_rd(2'd2, d); pr++;
         chk(d == 32'hBEEF_0000 + i, "R4 pop window order", d, 32'hBEEF_0000 + i);
      end
      bus_rd(2'd2, d); chk(d == 32'h0, "R4 empty pop returns zero", d, 0);
      bus_rd(2'd3, d); chk(d == exp_pst(), "R4 empty pop keeps pointers", d, exp_pst());
   endtask

   task automatic t_wrap;
      logic [31:0] d;
      for (int i = 0; i < 240; i++) begin
         host_push(32'hAA00_0000 + i);
         peer_pop_chk(32'hAA00_0000 + i, "R5 data across wrap");
      end
      bus_rd(2'd1, d); chk(d == 32'h1003_0320, "R5 pointers wrap mod 256", d, 32'h1003_0320);
   endtask

   task automatic t_irq;
      logic [31:0] d;
      pulse_event();
      bus_rd(2'd1, d); chk(d[7:0] == 8'h22, "R6 event sets pending", d, exp_ctl(8'h02));
      chk(!host_irq, "R7 masked while disabled", host_irq, 0);
      bus_wr(2'd1, 32'h0);
      bus_rd(2'd1, d); chk(d[7:0] == 8'h22, "R6 zero write keeps pending", d, exp_ctl(8'h02));
      bus_wr(2'd1, 32'h1);
      chk(host_irq, "R7 irq when enabled and pending", host_irq, 1);
      bus_wr(2'd1, 32'h3);
      chk(!host_irq, "R6 one clears pending", host_irq, 0);
      bus_rd(2'd1, d); chk(d == exp_ctl(8'h01), "R6 cleared state", d, exp_ctl(8'h01));
   endtask

   task automatic t_doorbell;
      logic [31:0] d;
      bus_wr(2'd1, 32'h5);
      chk(doorbell, "R8 pulse after trigger", doorbell, 1);
      tick();
      chk(!doorbell, "R8 pulse is one cycle", doorbell, 0);
      bus_rd(2'd1, d); chk(d == exp_ctl(8'h01), "R8 trigger reads zero", d, exp_ctl(8'h01));
   endtask

   task automatic t_ready;
      logic [31:0] d;
      peer_ready = 1'b0;
      bus_wr(2'd1, 32'h9);
      chk(!host_ready, "R10 refused without peer ready", host_ready, 0);
      peer_ready = 1'b1;
      bus_wr(2'd1, 32'h9);
      chk(host_ready, "R10 accepted with peer ready", host_ready, 1);
      bus_rd(2'd1, d); chk(d == exp_ctl(8'h09), "R10 ready bit", d, exp_ctl(8'h09));
   endtask

   task automatic t_reset_seq;
      logic [31:0] d;
      host_push(32'h1234_0001);
      host_push(32'h1234_0002);
      pulse_event();
      bus_wr(2'd1, 32'h19);
      chk(host_in_reset && !host_ready, "R9 reset entry drops ready",
          {host_in_reset, host_ready}, 2);
      bus_rd(2'd1, d); chk(d == exp_ctl(8'h13), "R9 reset held state", d, exp_ctl(8'h13));
      bus_wr(2'd1, 32'h19);
      bus_rd(2'd1, d); chk(d == exp_ctl(8'h13), "R9 second reset no effect", d, exp_ctl(8'h13));
      chk(!host_ready, "R10 ready refused in reset", host_ready, 0);
      bus_wr(2'd1, 32'h1);
      hw = 0; hr = 0; pw = 0; pr = 0; hovf = 0; povf = 0;
      chk(!pr_has_data && !host_in_reset, "R9 release empties outbound",
          {pr_has_data, host_in_reset}, 0);
      bus_rd(2'd1, d); chk(d == 32'h1000_0001, "R9 release clears pointers", d, 32'h1000_0001);
      bus_rd(2'd3, d); chk(d == 32'h1000_0001, "R9 release clears inbound", d, 32'h1000_0001);
      bus_wr(2'd1, 32'h9);
      chk(host_ready, "R10 ready after release", host_ready, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_push_basic();
      t_out_full();
      t_in_path();
      t_wrap();
      t_irq();
      t_doorbell();
      t_ready();
      t_reset_seq();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule